// File: doc/BRIEF.md
# Suspendable System Clock Controller

This block turns a free-running internal oscillator clock into a system clock-enable pulse. The pulse repeats at the oscillator rate divided by a power of two between 1 and 128, and that ratio is chosen through a small control register. Logic downstream of the block advances only in cycles where the enable is high. After reset the oscillator is the clock source and the slowest ratio is selected.

Software can also suspend the system clock by setting a control bit. The enable then stays low until a hardware wake condition appears. Any of four port-match lines counts as a wake condition, and so does an enabled comparator whose output is low. The wake logic runs on the undivided oscillator clock, so it keeps working while the enable is held off. On a wake the suspend bit clears itself and the divider starts over from zero. This happens whether or not the same event also raises an interrupt elsewhere in the chip.

Top module: `sysclk_suspend_ctrl`

## Requirements
- R1: After reset the control register reads 8'h07 (divide code 7, suspend bit 0), suspended is 0, and the first clkEn pulse comes in the 128th oscillator cycle after reset is released.
- R2: With divide code n in ctrlReg[2:0], clkEn is high for exactly one cycle out of every 2^n oscillator cycles. Code 0 makes clkEn high in every cycle.
- R3: Any write to the control register restarts the divider from zero, so the first pulse after the write edge comes in the 2^n-th cycle after that edge.
- R4: A write with bit 4 (the suspend bit) set and no wake condition present sets suspended and ctrlReg[4] from the next cycle. The block stays suspended while no wake condition occurs, and clkEn stays low the whole time.
- R5: While suspended, a high level on any one of portMatch[3:0] clears suspended and ctrlReg[4] on the next clock edge.
- R6: While suspended, cmpEnable=1 together with cmpOut=0 wakes the block. cmpEnable=0, or cmpOut=1, does not wake it.
- R7: A suspend write made in a cycle where a wake condition is already present leaves suspended at 0.
- R8: After a wake, the first clkEn pulse comes in the 2^n-th cycle after the wake edge.
- R9: Wake conditions present while the block is not suspended do not change the clkEn cadence or the register contents.
- R10: ctrlReg bits 7:5 and bit 3 always read 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Write data: [2:0] divide code, [4] suspend |
| portMatch | input | 4 | Port-match wake event lines |
| cmpEnable | input | 1 | Comparator enabled |
| cmpOut | input | 1 | Comparator output level |
| clkEn | output | 1 | Divided system clock-enable pulse |
| suspended | output | 1 | High while the clock is suspended |
| ctrlReg | output | 8 | Readable control register |

## Verification
The hardest case to reach is a wake condition that is already present in the same cycle as the suspend write. It needs the write strobe and a port-match level to reach the same oscillator edge. The bench drives both from one falling edge and then checks the suspended flag at the next falling edge. The comparator-level wake is also hard to reach in isolation. The bench holds the block suspended and steps through each comparator enable and output combination that must not wake it before applying the one that must. At each step it checks that suspension is still in force.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  // Strobes from control to the divider datapath
  typedef struct packed {
    logic cntClear;   // restart the divider at zero this edge
    logic gateOpen;   // allow terminal count to become an enable pulse
  } divStrobe_t;

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int CODE_W    = 3,
  parameter int SUSP_BIT  = 4,
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [NUM_PORTS-1:0] portMatch,
  input  logic                 cmpEnable,
  input  logic                 cmpOut,
  output logic [CODE_W-1:0]    divCode,
  output logic                 suspendQ,
  output logic [REG_W-1:0]     ctrlReg,
  output divStrobe_t           strobe
);

  localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'((1 << CODE_W) - 1);

  logic [NUM_PORTS-1:0] portWake;
  logic                 cmpWake;
  logic                 wake;

  // One wake source per port line
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portWake
    assign portWake[p] = portMatch[p];
  end

  assign cmpWake = cmpEnable & ~cmpOut;
  assign wake    = (|portWake) | cmpWake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCode  <= RESET_CODE;
      suspendQ <= 1'b0;
    end else if (regWrEn) begin
      divCode  <= regWrData[CODE_W-1:0];
      suspendQ <= regWrData[SUSP_BIT] & ~wake;
    end else if (suspendQ && wake) begin
      suspendQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlReg                 = '0;
    ctrlReg[CODE_W-1:0]     = divCode;
    ctrlReg[SUSP_BIT]       = suspendQ;
  end

  always_comb begin
    strobe.cntClear = regWrEn | suspendQ;
    strobe.gateOpen = ~suspendQ;
  end

  assert_enter_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[SUSP_BIT] && !wake) |=> suspendQ);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (suspendQ && !regWrEn && !wake) |=> suspendQ);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (suspendQ && !regWrEn && wake) |=> !suspendQ);

  assert_collide_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[SUSP_BIT] && wake) |=> !suspendQ);

endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider
  import clkctl_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  divStrobe_t        strobe,
  output logic              clkEn
);

  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termCount;
  logic             atTerm;

  // Terminal count 2^n - 1 as a thermometer mask
  for (genvar i = 0; i < CNT_W; i++) begin : g_term
    assign termCount[i] = (i < int'(divCode));
  end

  assign atTerm = (cnt == termCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (atTerm)          cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign clkEn = atTerm & strobe.gateOpen;

  assert_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termCount);

  assert_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !strobe.cntClear && termCount != '0) |=> !clkEn);

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (cnt == '0));

endmodule

// File: rtl/sysclk_suspend_ctrl.sv
module sysclk_suspend_ctrl
  import clkctl_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int CODE_W    = 3,
  parameter int SUSP_BIT  = 4,
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [NUM_PORTS-1:0] portMatch,
  input  logic                 cmpEnable,
  input  logic                 cmpOut,
  output logic                 clkEn,
  output logic                 suspended,
  output logic [REG_W-1:0]     ctrlReg
);

  divStrobe_t        strobe;
  logic [CODE_W-1:0] divCode;

  clkctl_ctrl #(
    .REG_W(REG_W), .CODE_W(CODE_W), .SUSP_BIT(SUSP_BIT), .NUM_PORTS(NUM_PORTS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .portMatch(portMatch), .cmpEnable(cmpEnable), .cmpOut(cmpOut),
    .divCode(divCode), .suspendQ(suspended), .ctrlReg(ctrlReg), .strobe(strobe)
  );

  clkctl_divider #(.CODE_W(CODE_W)) div_i (
    .clk(clk), .rstN(rstN), .divCode(divCode), .strobe(strobe), .clkEn(clkEn)
  );

  assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !clkEn);

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[REG_W-1:SUSP_BIT+1] == '0) && (ctrlReg[SUSP_BIT-1:CODE_W] == '0));

endmodule

// File: tb/sysclk_suspend_ctrl_tb.sv
module sysclk_suspend_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [3:0] portMatch = '0;
  logic       cmpEnable = 1'b0;
  logic       cmpOut = 1'b1;
  logic       clkEn;
  logic       suspended;
  logic [7:0] ctrlReg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  sysclk_suspend_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .portMatch(portMatch), .cmpEnable(cmpEnable), .cmpOut(cmpOut),
    .clkEn(clkEn), .suspended(suspended), .ctrlReg(ctrlReg)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Write at one negedge; returns at the negedge after the write edge (k=1)
  task automatic writeReg(logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  // Starting at negedge k=1 after an edge, count negedges until clkEn high
  task automatic cyclesToPulse(output int k);
    k = 1;
    while (!clkEn && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic testReset();
    int k;
    @(negedge clk);
    rstN = 1'b1;  // counter is zero at this negedge
    check("R1 ctrlReg", ctrlReg, 8'h07);
    check("R1 suspended", suspended, 0);
    k = 0;
    while (!clkEn && k < 300) begin
      @(negedge clk);
      k++;
    end
    check("R1 first pulse", k, 127);
  endtask

  task automatic testRatio(int code);
    int k;
    int ones;
    writeReg(8'(code));
    check("R3 ctrlReg", ctrlReg, code);
    cyclesToPulse(k);
    check("R3 first pulse", k, 1 << code);
    ones = 0;
    for (int c = 0; c < 2 * (1 << code); c++) begin
      @(negedge clk);
      if (clkEn) ones++;
    end
    check("R2 pulses per two periods", ones, 2);
    if (code != 0) begin
      cyclesToPulse(k);
      @(negedge clk);
      check("R2 single-cycle pulse", clkEn, 0);
    end
  endtask

  task automatic testPortWake(int port);
    int k;
    int seen;
    writeReg(8'h14);
    check("R4 suspended", suspended, 1);
    check("R4 ctrlReg", ctrlReg, 8'h14);
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (clkEn) seen++;
    end
    check("R4 no pulse while suspended", seen, 0);
    check("R4 still suspended", suspended, 1);
    portMatch[port] = 1'b1;
    @(negedge clk);
    portMatch = '0;
    check("R5 woke", suspended, 0);
    check("R5 ctrlReg", ctrlReg, 8'h04);
    cyclesToPulse(k);
    check("R8 first pulse after wake", k, 16);
  endtask

  task automatic testCmpWake();
    writeReg(8'h12);
    cmpEnable = 1'b0; cmpOut = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 disabled cmp no wake", suspended, 1);
    cmpEnable = 1'b1; cmpOut = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 cmp high no wake", suspended, 1);
    cmpOut = 1'b0;
    @(negedge clk);
    check("R6 cmp low wakes", suspended, 0);
    cmpEnable = 1'b0; cmpOut = 1'b1;
  endtask

  task automatic testCollide();
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = 8'h13;
    portMatch = 4'b0100;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
    portMatch = '0;
    check("R7 not suspended", suspended, 0);
    check("R7 ctrlReg", ctrlReg, 8'h03);
  endtask

  task automatic testIgnoredWake();
    int ones;
    portMatch = 4'b1111;
    cmpEnable = 1'b1; cmpOut = 1'b0;
    writeReg(8'h02);
    ones = clkEn ? 1 : 0;
    for (int c = 2; c <= 20; c++) begin
      @(negedge clk);
      if (clkEn) ones++;
    end
    check("R9 cadence unchanged", ones, 5);
    check("R9 ctrlReg unchanged", ctrlReg, 8'h02);
    portMatch = '0;
    cmpEnable = 1'b0; cmpOut = 1'b1;
  endtask

  task automatic testReserved();
    writeReg(8'hEF);
    check("R10 reserved bits", ctrlReg, 8'h07);
    writeReg(8'h08);
    check("R10 reserved bit3", ctrlReg, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testRatio(0);
    testRatio(1);
    testRatio(3);
    testRatio(7);
    for (int p = 0; p < 4; p++) testPortWake(p);
    testCmpWake();
    testCollide();
    testIgnoredWake();
    testReserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule